// File: doc/BRIEF.md
# Search command front end

This block sits in front of a content-addressable lookup core and turns one of two control styles into a single registered operation strobe. In direct mode the caller drives a combined address/control bus, a segment-select pin and a write pin every cycle; each selected cycle becomes either a random memory access or a control state. In programmed mode the caller instead writes instructions over the data bus into an instruction register, then moves data in plain data cycles. The instruction stays in place and is applied to every later data cycle until a new one is written.

The issued operation carries an opcode, a mask-register select, a segment select, a read/write direction, a flag that says whether the data bus takes part, a random-access flag and an address. In programmed mode a read with the address-valid pin high returns a status word built from the core's search results. Selection combines two active-low chip-select pins with a device-select register that is compared against the configured page address. All inputs are sampled on the rising clock edge. The results appear on registered outputs in the following cycle as one-cycle pulses.

Top module: `search_cmd_front`

## Requirements
- R1: `cfg_mode` 2'b00 selects direct mode and 2'b11 selects programmed mode; with 2'b01 or 2'b10 no operation and no status read is issued.
- R2: Direct mode, selected, `av_n`=0: a random access is issued with `op_random`=1, `op_data_phase`=1, `op_addr`=`ctl_bus`, `op_seg`=`seg_sel`, `op_write`=!`wr_n`, `op_code`=0 and `op_mask`=0.
- R3: Direct mode, selected, `av_n`=1: a control state is issued with `op_code`=`ctl_bus[5:0]`, `op_mask`=`ctl_bus[8:6]`, `op_seg`=`seg_sel`, `op_write`=!`wr_n`, `op_random`=0, `op_addr`=0 and `op_data_phase` equal to opcode bit 5.
- R4: Programmed mode, selected, `av_n`=1, `wr_n`=0: the instruction register loads opcode `dq_in[5:0]`, mask `dq_in[8:6]`, segment `dq_in[12]` and write-low `dq_in[13]`. If opcode bit 5 is 0 (data-less), the operation is issued from that same sample with `op_data_phase`=0 and `op_write`=!`dq_in[13]`.
- R5: Programmed mode: an instruction whose opcode bit 5 is 1 is not issued when it is loaded. Each later selected cycle with `av_n`=0 issues it with `op_data_phase`=1, until another instruction is loaded.
- R6: Programmed mode, selected, `av_n`=0, with no instruction loaded since reset or with a data-less instruction held: nothing is issued.
- R7: Programmed mode, selected, `av_n`=1, `wr_n`=1: `stat_valid` pulses and no operation is issued. `stat_data` is {10'b0, `st_kind`, `st_full_n`, `st_multi_n`, `st_match_n`, `page_addr`, `st_addr`}, with the address in bits 12:0.
- R8: In programmed mode `op_random` and `op_addr` stay 0, and `ctl_bus` and `seg_sel` have no effect on the outputs.
- R9: The block is selected when `cs_a_n` or `cs_b_n` is 0. When unselected it issues nothing, returns no status and loads no instruction.
- R10: Opcode 6'h3A issued with write direction stores `dq_in[4:0]` into the device-select register. This happens in the control cycle in direct mode and in the data cycle in programmed mode. When stored bit 4 is 0 and bits 3:0 equal `page_addr`, the block is selected with both chip-select pins high.
- R11: After reset all outputs are 0, no instruction is held and the device-select register is disabled (bit 4 = 1).
- R12: Results appear in the cycle after the sampling edge and last one cycle; with nothing issued, every `op_*` field is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the rising edge samples all inputs |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 2 | Control-style field: 00 direct, 11 programmed |
| page_addr | input | 4 | Configured page address of this block |
| cs_a_n | input | 1 | Chip select A, active low |
| cs_b_n | input | 1 | Chip select B, active low |
| wr_n | input | 1 | Write pin, low means write |
| av_n | input | 1 | Address-valid pin, low means address/data cycle |
| seg_sel | input | 1 | Segment select: 0 low half, 1 high half (direct mode) |
| ctl_bus | input | 13 | Address or control state (direct mode) |
| dq_in | input | 32 | Data bus; carries instructions in programmed mode |
| st_addr | input | 13 | Core's current active address |
| st_match_n | input | 1 | Core match flag, active low |
| st_multi_n | input | 1 | Core multiple-match flag, active low |
| st_full_n | input | 1 | Core full flag, active low |
| st_kind | input | 2 | Type of cycle that produced the active address |
| op_valid | output | 1 | One-cycle operation strobe |
| op_code | output | 6 | Operation code |
| op_mask | output | 3 | Mask-register select |
| op_seg | output | 1 | Segment select of the operation |
| op_write | output | 1 | 1 for write, 0 for read |
| op_data_phase | output | 1 | Data bus takes part in this operation |
| op_random | output | 1 | Operation is a random memory access |
| op_addr | output | 13 | Random-access address |
| stat_valid | output | 1 | One-cycle status-read strobe |
| stat_data | output | 32 | Status word |

## Verification
On every cycle the assertions check these properties: nothing is issued without selection, an unsupported mode stays silent, programmed mode never yields a random access, a status read and an operation never coincide, a random access always carries a data phase, a programmed load never issues a data-carrying operation, and idle outputs are zero. Some behaviour only the bench's scenarios can show. This covers instruction persistence across several data cycles, the same-cycle execution of data-less instructions, and the exact fields of each issued operation. It also covers the device-select register turning selection on and off, and the packing of the status word. These scenarios are checked against a reference model of the requirements under random traffic.

// File: rtl/scf_pkg.sv
// Shared widths, encodings and types for the search command front end.
// Assumes an instruction layout of opcode, then mask select, then segment
// and write-low bits at fixed data-bus positions.
package scf_pkg;
    localparam int ADDR_W  = 13;
    localparam int DATA_W  = 32;
    localparam int PAGE_W  = 4;
    localparam int OP_W    = 6;
    localparam int MASK_W  = 3;
    localparam int KIND_W  = 2;
    localparam int SEG_BIT = 12;
    localparam int WRN_BIT = 13;
    localparam int DP_BIT  = OP_W - 1;
    localparam int DS_W    = PAGE_W + 1;
    localparam int STAT_USED = ADDR_W + PAGE_W + 3 + KIND_W;

    localparam logic [1:0] MODE_DIRECT = 2'b00;
    localparam logic [1:0] MODE_PROG   = 2'b11;
    localparam logic [OP_W-1:0] OP_DEVSEL_WR = 6'h3A;

    typedef struct packed {
        logic              valid;
        logic              random;
        logic              dphase;
        logic              wr;
        logic              seg;
        logic [MASK_W-1:0] mask;
        logic [OP_W-1:0]   code;
        logic [ADDR_W-1:0] addr;
    } op_t;

    typedef struct packed {
        logic              wr;
        logic              seg;
        logic [MASK_W-1:0] mask;
        logic [OP_W-1:0]   code;
    } instr_t;

    function automatic logic carries_data(input logic [OP_W-1:0] code);
        return code[DP_BIT];
    endfunction
endpackage

// File: rtl/scf_select.sv
// Selection unit: holds the device-select register and combines it with
// the two active-low chip-select pins. Assumes the register write strobe
// is already qualified by the decoder.
module scf_select
    import scf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_a_n,
    input  logic              cs_b_n,
    input  logic [PAGE_W-1:0] page_addr,
    input  logic              ds_we,
    input  logic [DS_W-1:0]   ds_din,
    output logic              dev_sel
);
    logic [DS_W-1:0] ds_q;
    logic            ds_match;

    // Device-select register; reset leaves the enable bit inactive (high).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ds_q <= {1'b1, {PAGE_W{1'b0}}};
        end else if (ds_we) begin
            ds_q <= ds_din;
        end
    end

    // Register-based selection plus the pin-based one.
    always_comb begin
        ds_match = !ds_q[PAGE_W] && (ds_q[PAGE_W-1:0] == page_addr);
        dev_sel  = !cs_a_n || !cs_b_n || ds_match;
    end
endmodule

// File: rtl/scf_instr_reg.sv
// Instruction register for programmed mode. It captures the instruction
// fields from the data bus on a qualified load and holds them until the
// next load. The valid flag shows that any instruction has been loaded.
module scf_instr_reg
    import scf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic              ir_valid,
    output instr_t            ir
);
    // Capture the fields on load, hold them otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_valid <= 1'b0;
            ir       <= '0;
        end else if (load) begin
            ir_valid <= 1'b1;
            ir.code  <= din[OP_W-1:0];
            ir.mask  <= din[OP_W+MASK_W-1:OP_W];
            ir.seg   <= din[SEG_BIT];
            ir.wr    <= !din[WRN_BIT];
        end
    end
endmodule

// File: rtl/scf_decode.sv
// Combinational decoder. It chooses between direct and programmed control
// and forms the next operation, the instruction-load strobe, the status-read
// strobe and the device-select write. It assumes the selection is computed
// from the current register state.
module scf_decode
    import scf_pkg::*;
(
    input  logic              dev_sel,
    input  logic [1:0]        cfg_mode,
    input  logic              wr_n,
    input  logic              av_n,
    input  logic              seg_sel,
    input  logic [ADDR_W-1:0] ctl_bus,
    input  logic [DATA_W-1:0] dq_in,
    input  logic              ir_valid,
    input  instr_t            ir,
    output op_t               op_nxt,
    output logic              ir_load,
    output logic              stat_rd,
    output logic              ds_we,
    output logic [DS_W-1:0]   ds_din
);
    logic [OP_W-1:0] dq_code;
    logic            unused_dq;

    assign dq_code   = dq_in[OP_W-1:0];
    assign ds_din    = dq_in[DS_W-1:0];
    assign unused_dq = ^{dq_in[DATA_W-1:WRN_BIT+1], dq_in[SEG_BIT-1:OP_W+MASK_W]};

    // Decode one sampled cycle into at most one action.
    always_comb begin
        op_nxt  = '0;
        ir_load = 1'b0;
        stat_rd = 1'b0;
        ds_we   = 1'b0;
        if (dev_sel && cfg_mode == MODE_DIRECT) begin
            if (!av_n) begin
                op_nxt.valid  = 1'b1;
                op_nxt.random = 1'b1;
                op_nxt.dphase = 1'b1;
                op_nxt.wr     = !wr_n;
                op_nxt.seg    = seg_sel;
                op_nxt.addr   = ctl_bus;
            end else begin
                op_nxt.valid  = 1'b1;
                op_nxt.code   = ctl_bus[OP_W-1:0];
                op_nxt.mask   = ctl_bus[OP_W+MASK_W-1:OP_W];
                op_nxt.wr     = !wr_n;
                op_nxt.seg    = seg_sel;
                op_nxt.dphase = carries_data(ctl_bus[OP_W-1:0]);
                ds_we = (ctl_bus[OP_W-1:0] == OP_DEVSEL_WR) && !wr_n;
            end
        end else if (dev_sel && cfg_mode == MODE_PROG) begin
            if (av_n && !wr_n) begin
                ir_load = 1'b1;
                if (!carries_data(dq_code)) begin
                    op_nxt.valid = 1'b1;
                    op_nxt.code  = dq_code;
                    op_nxt.mask  = dq_in[OP_W+MASK_W-1:OP_W];
                    op_nxt.seg   = dq_in[SEG_BIT];
                    op_nxt.wr    = !dq_in[WRN_BIT];
                end
            end else if (av_n) begin
                stat_rd = 1'b1;
            end else if (ir_valid && carries_data(ir.code)) begin
                op_nxt.valid  = 1'b1;
                op_nxt.dphase = 1'b1;
                op_nxt.code   = ir.code;
                op_nxt.mask   = ir.mask;
                op_nxt.seg    = ir.seg;
                op_nxt.wr     = ir.wr;
                ds_we = (ir.code == OP_DEVSEL_WR) && ir.wr;
            end
        end
    end
endmodule

// File: rtl/scf_status.sv
// Status return for programmed mode. On a status read it packs the core's
// search results with the page address into one word for a single cycle.
// Assumes the result inputs are stable around the sampling edge.
module scf_status
    import scf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [PAGE_W-1:0] page_addr,
    input  logic              st_match_n,
    input  logic              st_multi_n,
    input  logic              st_full_n,
    input  logic [KIND_W-1:0] st_kind,
    output logic              stat_valid,
    output logic [DATA_W-1:0] stat_data
);
    localparam int PAD_W = DATA_W - STAT_USED;

    // Register the packed word on a read; otherwise clear it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_valid <= 1'b0;
            stat_data  <= '0;
        end else begin
            stat_valid <= rd;
            stat_data  <= rd ? {{PAD_W{1'b0}}, st_kind, st_full_n, st_multi_n,
                                st_match_n, page_addr, st_addr} : '0;
        end
    end
endmodule

// File: rtl/search_cmd_front.sv
// Top of the search command front end. It connects selection, the
// instruction register, the decoder and status return, and registers the
// issued operation as a one-cycle pulse. Assumes the rising clock edge
// stands in for the sampling edge of the external chip enable.
module search_cmd_front
    import scf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_mode,
    input  logic [PAGE_W-1:0] page_addr,
    input  logic              cs_a_n,
    input  logic              cs_b_n,
    input  logic              wr_n,
    input  logic              av_n,
    input  logic              seg_sel,
    input  logic [ADDR_W-1:0] ctl_bus,
    input  logic [DATA_W-1:0] dq_in,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic              st_match_n,
    input  logic              st_multi_n,
    input  logic              st_full_n,
    input  logic [KIND_W-1:0] st_kind,
    output logic              op_valid,
    output logic [OP_W-1:0]   op_code,
    output logic [MASK_W-1:0] op_mask,
    output logic              op_seg,
    output logic              op_write,
    output logic              op_data_phase,
    output logic              op_random,
    output logic [ADDR_W-1:0] op_addr,
    output logic              stat_valid,
    output logic [DATA_W-1:0] stat_data
);
    logic            dev_sel;
    logic            ds_we;
    logic [DS_W-1:0] ds_din;
    logic            ir_load;
    logic            ir_valid;
    instr_t          ir;
    logic            stat_rd;
    op_t             op_nxt;
    op_t             op_q;

    scf_select u_select (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_a_n    (cs_a_n),
        .cs_b_n    (cs_b_n),
        .page_addr (page_addr),
        .ds_we     (ds_we),
        .ds_din    (ds_din),
        .dev_sel   (dev_sel)
    );

    scf_instr_reg u_ir (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ir_load),
        .din      (dq_in),
        .ir_valid (ir_valid),
        .ir       (ir)
    );

    scf_decode u_dec (
        .dev_sel  (dev_sel),
        .cfg_mode (cfg_mode),
        .wr_n     (wr_n),
        .av_n     (av_n),
        .seg_sel  (seg_sel),
        .ctl_bus  (ctl_bus),
        .dq_in    (dq_in),
        .ir_valid (ir_valid),
        .ir       (ir),
        .op_nxt   (op_nxt),
        .ir_load  (ir_load),
        .stat_rd  (stat_rd),
        .ds_we    (ds_we),
        .ds_din   (ds_din)
    );

    scf_status u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd         (stat_rd),
        .st_addr    (st_addr),
        .page_addr  (page_addr),
        .st_match_n (st_match_n),
        .st_multi_n (st_multi_n),
        .st_full_n  (st_full_n),
        .st_kind    (st_kind),
        .stat_valid (stat_valid),
        .stat_data  (stat_data)
    );

    // Operation output register: a one-cycle pulse per decoded cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) op_q <= '0;
        else        op_q <= op_nxt;
    end

    assign op_valid      = op_q.valid;
    assign op_code       = op_q.code;
    assign op_mask       = op_q.mask;
    assign op_seg        = op_q.seg;
    assign op_write      = op_q.wr;
    assign op_data_phase = op_q.dphase;
    assign op_random     = op_q.random;
    assign op_addr       = op_q.addr;

    AST_MODE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_mode) != MODE_DIRECT && $past(cfg_mode) != MODE_PROG) |-> (!op_valid && !stat_valid)); // R1
    AST_RANDOM_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_random) |-> op_data_phase); // R2
    AST_LOAD_NO_DATA_OP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dev_sel) && $past(cfg_mode) == MODE_PROG && $past(av_n) && !$past(wr_n)) |-> !op_data_phase); // R4
    AST_STAT_PROG_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |-> ($past(cfg_mode) == MODE_PROG && !op_valid)); // R7
    AST_PROG_NO_RANDOM: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && $past(cfg_mode) == MODE_PROG) |-> (!op_random && op_addr == '0)); // R8
    AST_SELECT_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid || stat_valid) |-> $past(dev_sel)); // R9
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |-> (op_code == '0 && op_mask == '0 && !op_random && !op_data_phase && op_addr == '0)); // R12
endmodule

// File: tb/search_cmd_front_tb.sv
module search_cmd_front_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 3000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_mode = 2'b00;
    logic [3:0]  page_addr = 4'h5;
    logic        cs_a_n = 1'b1, cs_b_n = 1'b1, wr_n = 1'b1, av_n = 1'b1, seg_sel = 1'b0;
    logic [12:0] ctl_bus = '0;
    logic [31:0] dq_in = '0;
    logic [12:0] st_addr = '0;
    logic        st_match_n = 1'b1, st_multi_n = 1'b1, st_full_n = 1'b1;
    logic [1:0]  st_kind = '0;
    logic        op_valid, op_seg, op_write, op_data_phase, op_random, stat_valid;
    logic [5:0]  op_code;
    logic [2:0]  op_mask;
    logic [12:0] op_addr;
    logic [31:0] stat_data;

    int n_tests = 0;
    int n_fail  = 0;

    // reference model state
    logic        m_ir_v = 1'b0;
    logic [13:0] m_ir = '0;
    logic [4:0]  m_ds = 5'h10;

    always #(CLK_PERIOD/2) clk = ~clk;

    search_cmd_front u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .page_addr(page_addr),
        .cs_a_n(cs_a_n), .cs_b_n(cs_b_n), .wr_n(wr_n), .av_n(av_n),
        .seg_sel(seg_sel), .ctl_bus(ctl_bus), .dq_in(dq_in),
        .st_addr(st_addr), .st_match_n(st_match_n), .st_multi_n(st_multi_n),
        .st_full_n(st_full_n), .st_kind(st_kind),
        .op_valid(op_valid), .op_code(op_code), .op_mask(op_mask), .op_seg(op_seg),
        .op_write(op_write), .op_data_phase(op_data_phase), .op_random(op_random),
        .op_addr(op_addr), .stat_valid(stat_valid), .stat_data(stat_data)
    );

    function automatic logic [26:0] actual_op();
        return {op_valid, op_random, op_data_phase, op_write, op_seg, op_mask, op_code, op_addr};
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Predict from the requirements, run one clock, compare, update model.
    task automatic step();
        logic [26:0] e_op = '0;
        logic [32:0] e_st = '0;
        string       req = "R9";
        logic        sel;
        sel = !cs_a_n || !cs_b_n || (!m_ds[4] && m_ds[3:0] == page_addr);
        if (!sel) req = "R9";
        else if (cfg_mode == 2'b00) begin
            if (!av_n) begin
                req  = "R2";
                e_op = {1'b1, 1'b1, 1'b1, !wr_n, seg_sel, 3'b0, 6'b0, ctl_bus};
            end else begin
                req  = (ctl_bus[5:0] == 6'h3A) ? "R10" : "R3";
                e_op = {1'b1, 1'b0, ctl_bus[5], !wr_n, seg_sel, ctl_bus[8:6], ctl_bus[5:0], 13'b0};
            end
        end else if (cfg_mode == 2'b11) begin
            if (av_n && !wr_n) begin
                req = dq_in[5] ? "R5" : "R4";
                if (!dq_in[5])
                    e_op = {1'b1, 1'b0, 1'b0, !dq_in[13], dq_in[12], dq_in[8:6], dq_in[5:0], 13'b0};
            end else if (av_n) begin
                req  = "R7";
                e_st = {1'b1, 10'b0, st_kind, st_full_n, st_multi_n, st_match_n, page_addr, st_addr};
            end else if (m_ir_v && m_ir[5]) begin
                req  = "R5";
                e_op = {1'b1, 1'b0, 1'b1, !m_ir[13], m_ir[12], m_ir[8:6], m_ir[5:0], 13'b0};
            end else req = "R6";
        end else req = "R1";
        @(posedge clk);
        @(negedge clk);
        check(actual_op() == e_op, req, 64'(actual_op()), 64'(e_op));
        check({stat_valid, stat_data} == e_st, req, 64'({stat_valid, stat_data}), 64'(e_st));
        if (sel && cfg_mode == 2'b00 && av_n && !wr_n && ctl_bus[5:0] == 6'h3A) m_ds = dq_in[4:0];
        if (sel && cfg_mode == 2'b11 && !av_n && m_ir_v && m_ir[5:0] == 6'h3A && !m_ir[13]) m_ds = dq_in[4:0];
        if (sel && cfg_mode == 2'b11 && av_n && !wr_n) begin
            m_ir_v = 1'b1;
            m_ir   = dq_in[13:0];
        end
    endtask

    task automatic drive(input logic [1:0] md, input logic ca, input logic cb, input logic w,
                         input logic av, input logic sg, input logic [12:0] cb_v, input logic [31:0] d);
        cfg_mode = md; cs_a_n = ca; cs_b_n = cb; wr_n = w; av_n = av;
        seg_sel = sg; ctl_bus = cb_v; dq_in = d;
        st_addr = 13'($urandom); {st_match_n, st_multi_n, st_full_n} = 3'($urandom);
        st_kind = 2'($urandom);
        step();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset state
        check(actual_op() == '0 && !stat_valid && stat_data == '0, "R11",
              64'({actual_op(), stat_valid}), 64'd0);
        rst_n = 1'b1;
        // R11/R9: device-select disabled after reset, pins high -> nothing
        drive(2'b00, 1, 1, 0, 0, 0, 13'h123, 32'h0);
        // R2: direct random access, read and write
        drive(2'b00, 0, 1, 0, 0, 1, 13'h1ABC, 32'h0);
        drive(2'b00, 1, 0, 1, 0, 0, 13'h0001, 32'h0);
        // R3: direct control states, data-less and data-carrying
        drive(2'b00, 0, 0, 1, 1, 1, 13'h01C5, 32'h0);
        drive(2'b00, 0, 1, 0, 1, 0, 13'h00A7, 32'h0);
        // R10: device-select write enables selection through page match
        drive(2'b00, 0, 1, 0, 1, 0, 13'h003A, 32'h0000_0005);
        drive(2'b00, 1, 1, 0, 0, 0, 13'h0444, 32'h0);
        drive(2'b00, 0, 1, 0, 1, 0, 13'h003A, 32'h0000_0015);
        drive(2'b00, 1, 1, 0, 0, 0, 13'h0444, 32'h0);
        // R1: unsupported mode is silent
        drive(2'b01, 0, 0, 0, 0, 0, 13'h0123, 32'h0);
        drive(2'b10, 0, 0, 1, 1, 0, 13'h0123, 32'h0);
        // R6: programmed data cycle without instruction
        drive(2'b11, 0, 1, 0, 0, 1, 13'h1FFF, 32'h0);
        // R4: data-less load executes at once, R6 afterwards
        drive(2'b11, 0, 1, 0, 1, 0, 13'h0, 32'h0000_1085);
        drive(2'b11, 0, 1, 1, 0, 0, 13'h0, 32'h0);
        // R5: data-carrying load waits, then persists; R8 pins ignored
        drive(2'b11, 0, 1, 0, 1, 0, 13'h0, 32'h0000_3161);
        for (int i = 0; i < 3; i++)
            drive(2'b11, 0, 1, 0, 0, 1'(i), 13'(i * 977), 32'(i));
        // R7: status read
        drive(2'b11, 1, 0, 1, 1, 0, 13'h0, 32'h0);
        // R9: unselected programmed load is ignored; R5 old instruction stays
        drive(2'b11, 1, 1, 0, 1, 0, 13'h0, 32'h0000_0003);
        drive(2'b11, 0, 1, 1, 0, 0, 13'h0, 32'h0);
        // R10 in programmed mode: data cycle with device-select write
        drive(2'b11, 0, 1, 0, 1, 0, 13'h0, 32'h0000_003A);
        drive(2'b11, 0, 1, 0, 0, 0, 13'h0, 32'h0000_0005);
        drive(2'b11, 1, 1, 1, 1, 0, 13'h0, 32'h0);
        // R12: idle cycle after an operation
        drive(2'b00, 0, 1, 1, 0, 0, 13'h0042, 32'h0);
        drive(2'b01, 1, 1, 1, 1, 0, 13'h0, 32'h0);
        // constrained random traffic
        for (int i = 0; i < N_RANDOM; i++) begin
            int r;
            logic [1:0] md;
            r  = int'($urandom % 20);
            md = (r < 9) ? 2'b00 : (r < 18) ? 2'b11 : 2'($urandom);
            drive(md, ($urandom % 3) != 0, ($urandom % 3) != 0, 1'($urandom), 1'($urandom),
                  1'($urandom), 13'($urandom), ($urandom % 8 == 0) ? 32'h3A | ($urandom & 32'h3000) : $urandom);
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule